// File: doc/BRIEF.md
# Paged Management Register Target on a Two-Wire Serial Bus

This block is the two-wire serial (I2C) target of a pluggable module's management interface. It answers one fixed 7-bit device address and only while the active-low select pin is low. It turns bus transactions into accesses on a synchronous register port. A byte pointer persists between transactions. It advances once for every data byte moved and wraps inside its own 128-byte half of the address space. It is loaded by the word-address byte of a write.

Location 127 of the lower half is held inside the block as the page selector. Accesses to addresses 128 to 255 go out on the register port tagged with that page number. Accesses to the lower half are tagged with page 0. The host may write bytes, read from the current pointer, load the pointer with a write that a repeated START abandons (random read), and stream reads by acknowledging each byte. SCL and SDA are synchronised and glitch-filtered on the system clock, which must run at least 16 times the SCL rate. SDA is driven only as a pull-down request.

The register port is a valid/ready request channel. A request holds its address, direction, page and write data stable until ready is seen high on a rising clock edge. For a read, the register file presents the byte on `reg_rdata` in the cycle after that handshake. Because the target does not stretch the clock, ready must arrive within a few system cycles of the request: the byte is needed before SCL falls at the end of the acknowledge slot.

Top module: `mgmt_i2c_target`

## Requirements
- R1: After a START, the block acknowledges the first byte only when its upper seven bits equal 1010000; bit 0 selects read (1) or write (0). Any other first byte is not acknowledged, and the block ignores the bus until the next START.
- R2: While `sel_n` is high, the block never pulls SDA low, issues no register request and leaves the pointer unchanged.
- R3: While `rst_n` is low, SDA is released and no request is issued. Afterwards the pointer and the page selector are both 0.
- R4: In a write, the second byte loads the pointer. Every later byte is acknowledged, written at the pointer, and advances the pointer by one.
- R5: Advancing the pointer changes only bits 6:0. Address 127 is followed by 0, and 255 by 128.
- R6: Address 127 reads and writes the internal page selector and is never sent to the register port. Addresses 128 to 255 go out with `reg_page` equal to the selector, and addresses 0 to 126 go out with `reg_page` 0.
- R7: A read with no preceding word address returns the byte at the pointer, then advances the pointer.
- R8: A repeated START after the word address abandons the write. The pointer holds the loaded word address, not that address plus one.
- R9: During a read, each byte the host acknowledges is followed by the next byte. A host NACK ends the read, and exactly one pointer step is taken per byte sent.
- R10: A START or STOP in the middle of a byte aborts the transfer without a register write, and the pointer keeps its value.
- R11: A pending request keeps valid, address, direction and write data stable until ready. Read data is taken in the cycle after the handshake.
- R12: SDA is only ever pulled low, never driven high, and a new pull-down begins only while the filtered SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16x SCL |
| rst_n | input | 1 | Active-low reset of the target |
| sel_n | input | 1 | Active-low module select |
| scl_i | input | 1 | SCL level seen at the pad |
| sda_i | input | 1 | SDA level seen at the pad |
| sda_pull | output | 1 | 1 = pull SDA low, 0 = release |
| reg_valid | output | 1 | Register request valid |
| reg_ready | input | 1 | Register file accepts the request |
| reg_write | output | 1 | 1 = write, 0 = read |
| reg_page | output | 8 | Page tag of the access |
| reg_addr | output | 8 | Byte address of the access |
| reg_wdata | output | 8 | Write data |
| reg_rdata | input | 8 | Read data, valid the cycle after a read handshake |

## Verification
The assertions check on every cycle the properties of single signals. SDA is released one cycle after deselection or a START. A pull-down only starts after SCL was low. A stalled request stays frozen. A pointer step never crosses a page boundary. The page selector's address never appears on the port. The bench's scenarios are needed for the properties that span whole transactions: address matching across all 128 device addresses, the pointer value left behind by write, random, current and streamed reads, the wrap of both halves, and page tagging of upper accesses. They also show that a mid-byte STOP, a deselected transfer and a reset leave no write behind.

// File: rtl/mgmt_i2c_pkg.sv
package mgmt_i2c_pkg;
  localparam int BYTE_W  = 8;
  localparam int HALF_AW = BYTE_W - 1;
  localparam logic [BYTE_W-1:0] PAGE_SEL_ADDR = {1'b0, {HALF_AW{1'b1}}};

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_WORD,
    ST_WORD_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK
  } tgt_state_e;
endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic level
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic          s1, s2;
  logic [CW-1:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1    <= 1'b1;
      s2    <= 1'b1;
      run   <= '0;
      level <= 1'b1;
    end else begin
      s1 <= pin;
      s2 <= s1;
      if (s2 == level) begin
        run <= '0;
      end else if (run == CW'(FILT_LEN - 1)) begin
        run   <= '0;
        level <= s2;
      end else begin
        run <= run + 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign scl_rise = scl_f & ~scl_q;
  assign scl_fall = ~scl_f & scl_q;
  assign start_ev = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_ev  = scl_f & scl_q & ~sda_q & sda_f;
endmodule

// File: rtl/mgmt_addr_ptr.sv
module mgmt_addr_ptr
  import mgmt_i2c_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic [BYTE_W-1:0] ld_val,
  input  logic              adv,
  input  logic              pg_we,
  input  logic [BYTE_W-1:0] pg_wdata,
  output logic [BYTE_W-1:0] ptr,
  output logic [BYTE_W-1:0] page
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr  <= '0;
      page <= '0;
    end else begin
      if (ld)
        ptr <= ld_val;
      else if (adv)
        ptr <= {ptr[BYTE_W-1], ptr[HALF_AW-1:0] + 1'b1};
      if (pg_we)
        page <= pg_wdata;
    end
  end

  // R5
  half_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv && !ld |=> ptr[BYTE_W-1] == $past(ptr[BYTE_W-1]));
endmodule

// File: rtl/mgmt_i2c_target.sv
module mgmt_i2c_target
  import mgmt_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ID   = 7'h50,
  parameter int         FILT_LEN = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull,
  output logic              reg_valid,
  input  logic              reg_ready,
  output logic              reg_write,
  output logic [BYTE_W-1:0] reg_page,
  output logic [BYTE_W-1:0] reg_addr,
  output logic [BYTE_W-1:0] reg_wdata,
  input  logic [BYTE_W-1:0] reg_rdata
);
  localparam int NLINES = 2;
  localparam int BC_W   = $clog2(BYTE_W + 1);

  logic [NLINES-1:0] raw, filt;
  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    i2c_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk   (clk),
      .rst_n (rst_n),
      .pin   (raw[g]),
      .level (filt[g])
    );
  end

  logic scl_f, sda_f;
  assign scl_f = filt[1];
  assign sda_f = filt[0];

  logic scl_rise, scl_fall, start_ev, stop_ev;
  i2c_bus_events u_ev (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_f    (scl_f),
    .sda_f    (sda_f),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  tgt_state_e        st;
  logic [BYTE_W-1:0] sh;
  logic [BC_W-1:0]   bitcnt;
  logic              ack_ph;
  logic              rw;
  logic              sda_low;
  logic [BYTE_W-1:0] rd_buf;
  logic              rd_cap;

  logic [BYTE_W-1:0] ptr, page;
  logic              active, last_bit, at_pg;
  logic [BYTE_W-1:0] rx_byte;
  logic              dev_hit, word_done, write_now, fetch_now;

  always_comb begin
    active    = !sel_n && !start_ev && !stop_ev;
    last_bit  = scl_rise && (bitcnt == BC_W'(BYTE_W - 1));
    rx_byte   = {sh[BYTE_W-2:0], sda_f};
    at_pg     = (ptr == PAGE_SEL_ADDR);
    dev_hit   = active && st == ST_DEV && last_bit && sh[6:0] == DEV_ID;
    word_done = active && st == ST_WORD && last_bit;
    write_now = active && st == ST_WDATA && last_bit;
    fetch_now = active && scl_rise &&
                ((st == ST_DEV_ACK && rw && ack_ph) || (st == ST_RACK && !sda_f));
  end

  mgmt_addr_ptr u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld       (word_done),
    .ld_val   (rx_byte),
    .adv      (fetch_now || write_now),
    .pg_we    (write_now && at_pg),
    .pg_wdata (rx_byte),
    .ptr      (ptr),
    .page     (page)
  );

  // bus-side sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      sh      <= '0;
      bitcnt  <= '0;
      ack_ph  <= 1'b0;
      rw      <= 1'b0;
      sda_low <= 1'b0;
    end else if (sel_n || stop_ev) begin
      st      <= ST_IDLE;
      sda_low <= 1'b0;
    end else if (start_ev) begin
      st      <= ST_DEV;
      bitcnt  <= '0;
      sda_low <= 1'b0;
    end else begin
      unique case (st)
        ST_DEV, ST_WORD, ST_WDATA: begin
          if (scl_rise) begin
            sh     <= rx_byte;
            bitcnt <= bitcnt + 1'b1;
            if (last_bit) begin
              bitcnt <= '0;
              ack_ph <= 1'b0;
              case (st)
                ST_DEV: begin
                  st <= dev_hit ? ST_DEV_ACK : ST_IDLE;
                  rw <= sda_f;
                end
                ST_WORD: st <= ST_WORD_ACK;
                default: st <= ST_WDATA_ACK;
              endcase
            end
          end
        end
        ST_DEV_ACK, ST_WORD_ACK, ST_WDATA_ACK: begin
          if (scl_fall) begin
            if (!ack_ph) begin
              sda_low <= 1'b1;
              ack_ph  <= 1'b1;
            end else begin
              sda_low <= 1'b0;
              bitcnt  <= '0;
              if (st == ST_DEV_ACK && rw) begin
                sh      <= rd_buf;
                sda_low <= ~rd_buf[BYTE_W-1];
                st      <= ST_RDATA;
              end else if (st == ST_DEV_ACK) begin
                st <= ST_WORD;
              end else begin
                st <= ST_WDATA;
              end
            end
          end
        end
        ST_RDATA: begin
          if (scl_rise) begin
            bitcnt <= bitcnt + 1'b1;
          end else if (scl_fall) begin
            if (bitcnt == BC_W'(BYTE_W)) begin
              sda_low <= 1'b0;
              ack_ph  <= 1'b0;
              st      <= ST_RACK;
            end else begin
              sh      <= sh << 1;
              sda_low <= ~sh[BYTE_W-2];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            if (sda_f) st <= ST_IDLE;
            else       ack_ph <= 1'b1;
          end else if (scl_fall && ack_ph) begin
            sh      <= rd_buf;
            sda_low <= ~rd_buf[BYTE_W-1];
            bitcnt  <= '0;
            st      <= ST_RDATA;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // register-port request channel
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_valid <= 1'b0;
      reg_write <= 1'b0;
      reg_page  <= '0;
      reg_addr  <= '0;
      reg_wdata <= '0;
      rd_cap    <= 1'b0;
      rd_buf    <= '0;
    end else begin
      rd_cap <= reg_valid && reg_ready && !reg_write;
      if (reg_valid && reg_ready)
        reg_valid <= 1'b0;
      if ((fetch_now || write_now) && !at_pg) begin
        reg_valid <= 1'b1;
        reg_write <= write_now;
        reg_addr  <= ptr;
        reg_page  <= ptr[BYTE_W-1] ? page : '0;
        reg_wdata <= rx_byte;
      end
      if (rd_cap)
        rd_buf <= reg_rdata;
      else if (fetch_now && at_pg)
        rd_buf <= page;
    end
  end

  assign sda_pull = sda_low;

  // R2
  desel_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |=> !sda_pull);

  // R10
  start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> !sda_pull);

  // R12
  pull_on_low_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !$past(scl_f));

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_valid && !reg_ready |=> reg_valid && $stable(reg_addr) &&
      $stable(reg_write) && $stable(reg_wdata) && $stable(reg_page));

  // R6
  page_sel_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_valid |-> reg_addr != PAGE_SEL_ADDR);
endmodule

// File: tb/sim_mgmt_i2c_target.sv
module sim_mgmt_i2c_target;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_pull, sda_bus;
  logic reg_valid, reg_ready, reg_write;
  logic [7:0] reg_page, reg_addr, reg_wdata;
  logic [7:0] reg_rdata;

  always #5 clk = ~clk;

  assign sda_bus = sda_m & ~sda_pull;

  mgmt_i2c_target u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_n     (sel_n),
    .scl_i     (scl_m),
    .sda_i     (sda_bus),
    .sda_pull  (sda_pull),
    .reg_valid (reg_valid),
    .reg_ready (reg_ready),
    .reg_write (reg_write),
    .reg_page  (reg_page),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata)
  );

  // register file model with rotating stall lengths
  logic [7:0] mem [0:1023];
  logic [7:0] exp_m [0:1023];
  logic [2:0] wcnt = '0;
  logic [1:0] stall_sel = '0;
  int         wr_count = 0;

  assign reg_ready = reg_valid && (wcnt >= {1'b0, stall_sel});

  always @(posedge clk) begin
    if (reg_valid && reg_ready) begin
      wcnt      <= '0;
      stall_sel <= stall_sel + 1'b1;
      reg_rdata <= mem[{reg_page[1:0], reg_addr}];
      if (reg_write) begin
        mem[{reg_page[1:0], reg_addr}] <= reg_wdata;
        wr_count <= wr_count + 1;
      end
    end else if (reg_valid) begin
      wcnt <= wcnt + 1'b1;
    end
  end

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] e_ptr = 8'h00;
  logic [7:0] e_page = 8'h00;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [7:0] nxt(input logic [7:0] a);
    return {a[7], a[6:0] + 7'd1};
  endfunction

  function automatic int idx(input logic [7:0] pg, input logic [7:0] a);
    return a[7] ? int'({pg[1:0], a}) : int'({2'b00, a});
  endfunction

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bit_out(input bit b);
    sda_m = b; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bit_in(output bit b);
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); b = sda_bus; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    bit x;
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    bit_in(x);
    ack = !x;
  endtask

  task automatic recv_byte(input bit last, output logic [7:0] b);
    bit x;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      bit_in(x);
      b = {b[6:0], x};
    end
    bit_out(last);
  endtask

  // model-side expected byte at current pointer
  function automatic logic [7:0] exp_at(input logic [7:0] a);
    return (a == 8'h7F) ? e_page : exp_m[idx(e_page, a)];
  endfunction

  task automatic read_stream(input int n, input string req);
    logic [7:0] got, ev;
    for (int k = 0; k < n; k++) begin
      recv_byte(k == n - 1, got);
      ev = exp_at(e_ptr);
      chk(got == ev, req, got, ev);
      e_ptr = nxt(e_ptr);
    end
    i2c_stop();
  endtask

  task automatic do_write(input logic [7:0] word, input int n, input int d0, input int step);
    bit ack;
    logic [7:0] d;
    i2c_start();
    send_byte(8'hA0, ack); chk(ack, "R4 dev ack", ack, 1);
    send_byte(word, ack);  chk(ack, "R4 word ack", ack, 1);
    e_ptr = word;
    for (int k = 0; k < n; k++) begin
      d = 8'(d0 + k * step);
      send_byte(d, ack); chk(ack, "R4 data ack", ack, 1);
      if (e_ptr == 8'h7F) e_page = d;
      else exp_m[idx(e_page, e_ptr)] = d;
      e_ptr = nxt(e_ptr);
    end
    i2c_stop();
  endtask

  task automatic do_rand_read(input logic [7:0] word, input int n, input string req);
    bit ack;
    i2c_start();
    send_byte(8'hA0, ack); chk(ack, "R8 dev ack", ack, 1);
    send_byte(word, ack);  chk(ack, "R8 word ack", ack, 1);
    e_ptr = word;
    i2c_start();
    send_byte(8'hA1, ack); chk(ack, "R1 read ack", ack, 1);
    read_stream(n, req);
  endtask

  task automatic do_cur_read(input int n, input string req);
    bit ack;
    i2c_start();
    send_byte(8'hA1, ack); chk(ack, "R7 read ack", ack, 1);
    read_stream(n, req);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) begin
      mem[i]   = 8'((i * 29 + 11) & 255);
      exp_m[i] = 8'((i * 29 + 11) & 255);
    end
  end

  initial begin
    bit ack;
    int w0;
    repeat (5) @(negedge clk);
    chk(sda_pull == 1'b0, "R3 reset sda", sda_pull, 0);
    chk(reg_valid == 1'b0, "R3 reset valid", reg_valid, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1: device address sweep, write direction
    for (int a = 0; a < 128; a++) begin
      i2c_start();
      send_byte(8'(a << 1), ack);
      chk(ack == (a == 'h50), "R1 address match", ack, a == 'h50);
      i2c_stop();
    end
    chk(wr_count == 0, "R1 no write on sweep", wr_count, 0);

    // R4 / R7: write three bytes, then read from current pointer
    do_write(8'h10, 3, 8'hA5, 3);
    chk(wr_count == 3, "R4 write count", wr_count, 3);
    do_cur_read(1, "R7 current read");
    // R8 / R9: random and sequential read
    do_rand_read(8'h10, 3, "R9 sequential read");
    do_cur_read(1, "R9 pointer after NACK");
    do_rand_read(8'h05, 1, "R8 random read");
    do_cur_read(1, "R8 pointer not bumped by aborted write");

    // R6 / R5: page selector and lower-half wrap
    w0 = wr_count;
    do_write(8'h7F, 1, 2, 0);
    chk(wr_count == w0, "R6 page byte not forwarded", wr_count, w0);
    do_rand_read(8'h7E, 3, "R5 lower wrap");

    // R5 / R6: upper half sweep on page 2 with wrap 255 -> 128
    w0 = wr_count;
    do_write(8'hC0, 68, 5, 37);
    chk(wr_count == w0 + 68, "R4 upper write count", wr_count, w0 + 68);
    do_rand_read(8'hC0, 70, "R5 upper wrap readback");
    do_write(8'h7F, 1, 1, 0);
    do_rand_read(8'hC0, 2, "R6 other page untouched");

    // R2: deselected module ignores a transfer
    w0 = wr_count;
    sel_n = 1'b1;
    i2c_start();
    send_byte(8'hA0, ack); chk(!ack, "R2 no ack when deselected", ack, 0);
    send_byte(8'h20, ack);
    send_byte(8'h99, ack);
    i2c_stop();
    sel_n = 1'b0;
    chk(wr_count == w0, "R2 no write when deselected", wr_count, w0);
    do_cur_read(1, "R2 pointer unchanged");

    // R10: STOP in the middle of a data byte
    w0 = wr_count;
    i2c_start();
    send_byte(8'hA0, ack);
    send_byte(8'h30, ack);
    e_ptr = 8'h30;
    for (int i = 0; i < 4; i++) bit_out(1'b1);
    i2c_stop();
    chk(wr_count == w0, "R10 no write after abort", wr_count, w0);
    do_cur_read(1, "R10 pointer kept");

    // R3: held in reset ignores the bus, then pointer and page are 0
    rst_n = 1'b0;
    i2c_start();
    send_byte(8'hA0, ack); chk(!ack, "R3 no ack in reset", ack, 0);
    i2c_stop();
    chk(reg_valid == 1'b0, "R3 no request in reset", reg_valid, 0);
    rst_n = 1'b1;
    e_ptr = 8'h00;
    e_page = 8'h00;
    repeat (5) @(negedge clk);
    do_cur_read(1, "R3 pointer zero after reset");
    do_rand_read(8'h7F, 1, "R3 page zero after reset");

    // R12: SDA high bits above came from the pull-up while sda_pull stayed 0
    chk(sda_pull == 1'b0, "R12 released when idle", sda_pull, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule